// File: doc/BRIEF.md
# ADC Conversion-Cycle Controller

This block is the device-side digital sequencer of a single-channel delta-sigma converter that talks to a host over a four-wire serial port. It repeats a fixed cycle: run a conversion for a programmed number of system-clock ticks, hold the result in a low-power wait, and then exchange data with the host while the host holds the select line low. The conversion result arrives as a parallel word from a modulator stand-in. The controller powers the converter only while a conversion runs. It can also drop the reference supply during the wait.

The host reads the held result MSB first, one bit per serial-clock falling edge. During the same exchange it may send a four-bit programming word. That word picks the conversion rate and chooses whether the reference sleeps. Reading the whole word, or raising the select line early, starts the next conversion at once. Each result therefore belongs to exactly one conversion, and no result is stale. All three serial inputs are brought into the system clock domain through two-flop synchronizers, and their edges are detected on the synchronized samples.

Top module: `adc_cycle_ctrl`

## Requirements
- R1: While `rst` is high and for `POR_TICKS` cycles after it falls, no conversion runs (`adc_pwr`=0) and `ref_pwr`=1. The first conversion then starts on its own. Reset clears the configuration to slow rate with the reference kept on.
- R2: A conversion keeps `adc_pwr` high for exactly `SLOW_TICKS` cycles at slow rate and `FAST_TICKS` cycles at fast rate. Activity on `cs_n`, `sck` or `sdi` during a conversion neither shortens nor stops it.
- R3: At the end of a conversion, `result_in` is captured into a held register. The block then waits with `adc_pwr`=0 until the synchronized `cs_n` is low, and only then enters data exchange.
- R4: On entering data exchange, `sdo` carries bit 15 of the held result. After each synchronized `sck` falling edge, it carries the next lower bit.
- R5: `sdi` is sampled on synchronized `sck` rising edges. If the first two bits are 1 then 0, the third bit sets the rate (1 = fast) and the fourth sets reference sleep (1 = sleep). Bits after the fourth have no effect.
- R6: A programming word whose first two bits are not 1 then 0 leaves the rate and the sleep setting unchanged.
- R7: The 16th `sck` falling edge ends the exchange and starts a new conversion. A rising edge of `cs_n` ends the exchange early and also starts a new conversion.
- R8: `sdo_oe` equals the inverse of `cs_n` delayed by two clocks. While `cs_n` is high, `sck` and `sdi` toggles start nothing and change nothing.
- R9: With reference sleep set, `ref_pwr` falls in the same cycle that `adc_pwr` falls at the end of the next conversion. It returns high once the synchronized `cs_n` goes low. With sleep clear, `ref_pwr` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial programming data from host |
| result_in | input | RES_W | Parallel result from the modulator stand-in |
| sdo | output | 1 | Serial result data |
| sdo_oe | output | 1 | Output enable for the external three-state `sdo` pad |
| adc_pwr | output | 1 | Converter power enable, high during a conversion |
| ref_pwr | output | 1 | Reference power enable |

## Verification
The assertions check on every cycle the fixed timing relations: the output enable trails `cs_n` by exactly two clocks, every conversion lasts one of the two programmed tick counts, the reference is powered whenever the converter is, and the reference only ever drops in the cycle a conversion ends. The directed scenarios cover what depends on sequence and data. These are the bit order of the shifted result, acceptance or rejection of a programming word, a rate change that applies only to the following conversion, early abort, serial activity ignored while deselected, and the sleep setting taking effect one conversion late and being undone by the next select.

// File: rtl/adc_cycle_pkg.sv
package adc_cycle_pkg;

    typedef enum logic [1:0] {
        PH_POR  = 2'd0,
        PH_CONV = 2'd1,
        PH_WAIT = 2'd2,
        PH_XFER = 2'd3
    } phase_t;

    typedef struct packed {
        logic fast;        // 1: short conversion period
        logic deep_sleep;  // 1: reference off while waiting
    } cfg_t;

    localparam logic [1:0] PROG_KEY = 2'b10;

    // Index of each serial pin inside the synchronizer vector
    localparam int PIN_CS  = 0;
    localparam int PIN_SCK = 1;
    localparam int PIN_SDI = 2;
    localparam int PIN_CNT = 3;

    function automatic logic prog_key_ok(input logic [3:0] word);
        return word[3:2] == PROG_KEY;
    endfunction

    function automatic cfg_t prog_decode(input logic [3:0] word);
        cfg_t c;
        c.fast       = word[1];
        c.deep_sleep = word[0];
        return c;
    endfunction

endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
    parameter int N = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] pin_s
);
    logic [N-1:0] stage1;
    logic [N-1:0] stage2;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[i] <= RST_VAL[i];
                stage2[i] <= RST_VAL[i];
            end else begin
                stage1[i] <= pin_in[i];
                stage2[i] <= stage1[i];
            end
        end
    end

    assign pin_s = stage2;
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int SLOW_TICKS = 400,
    parameter int FAST_TICKS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic fast,
    output logic done
);
    localparam int MAX_TICKS = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
    localparam int CW        = $clog2(MAX_TICKS + 1);

    logic [CW-1:0] cnt;
    logic          run;

    assign done = run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= fast ? CW'(FAST_TICKS - 1) : CW'(SLOW_TICKS - 1);
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/adc_xfer_port.sv
module adc_xfer_port
    import adc_cycle_pkg::*;
#(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [RES_W-1:0] load_val,
    input  logic             active,
    input  logic             sck_rise,
    input  logic             sck_fall,
    input  logic             sdi_s,
    output logic             sdo_bit,
    output logic             last_fall,
    output logic             cfg_we,
    output cfg_t             cfg_new
);
    localparam int FW = $clog2(RES_W);

    logic [RES_W-1:0] shreg;
    logic [FW-1:0]    fall_cnt;
    logic [2:0]       rise_cnt;
    logic [2:0]       head;
    logic [3:0]       word;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            fall_cnt <= '0;
            rise_cnt <= '0;
            head     <= '0;
        end else begin
            if (load)
                shreg <= load_val;
            else if (active && sck_fall)
                shreg <= {shreg[RES_W-2:0], 1'b0};

            if (!active) begin
                fall_cnt <= '0;
                rise_cnt <= '0;
            end else begin
                if (sck_fall) fall_cnt <= fall_cnt + 1'b1;
                if (sck_rise && rise_cnt != 3'd4) begin
                    head     <= {head[1:0], sdi_s};
                    rise_cnt <= rise_cnt + 1'b1;
                end
            end
        end
    end

    assign word      = {head, sdi_s};
    assign cfg_we    = active && sck_rise && (rise_cnt == 3'd3) && prog_key_ok(word);
    assign cfg_new   = prog_decode(word);
    assign last_fall = active && sck_fall && (fall_cnt == FW'(RES_W - 1));
    assign sdo_bit   = shreg[RES_W-1];
endmodule

// File: rtl/adc_cycle_ctrl.sv
module adc_cycle_ctrl
    import adc_cycle_pkg::*;
#(
    parameter int RES_W      = 16,
    parameter int SLOW_TICKS = 400,
    parameter int FAST_TICKS = 100,
    parameter int POR_TICKS  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             sdi,
    input  logic [RES_W-1:0] result_in,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             adc_pwr,
    output logic             ref_pwr
);
    localparam int PW = $clog2(POR_TICKS + 1);

    logic [PIN_CNT-1:0] pin_s;
    logic cs_s, sck_s, sdi_s;
    logic cs_prev, sck_prev;
    logic cs_rise, sck_rise, sck_fall;

    phase_t        phase, phase_nxt;
    logic [PW-1:0] por_cnt;
    logic          por_done;
    cfg_t          cfg, cfg_new;
    logic          cfg_we;
    logic          ref_off;
    logic          go_conv, tmr_done, last_fall, load;

    adc_pin_sync #(.N(PIN_CNT), .RST_VAL(PIN_CNT'(1) << PIN_CS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_in ({sdi, sck, cs_n}),
        .pin_s  (pin_s)
    );

    assign cs_s  = pin_s[PIN_CS];
    assign sck_s = pin_s[PIN_SCK];
    assign sdi_s = pin_s[PIN_SDI];

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            cs_prev  <= cs_s;
            sck_prev <= sck_s;
        end
    end

    assign cs_rise  = cs_s & ~cs_prev;
    assign sck_rise = sck_s & ~sck_prev;
    assign sck_fall = ~sck_s & sck_prev;

    adc_conv_timer #(.SLOW_TICKS(SLOW_TICKS), .FAST_TICKS(FAST_TICKS)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (go_conv),
        .fast  (cfg.fast),
        .done  (tmr_done)
    );

    assign load = (phase == PH_CONV) && tmr_done;

    adc_xfer_port #(.RES_W(RES_W)) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_val  (result_in),
        .active    (phase == PH_XFER),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .sdi_s     (sdi_s),
        .sdo_bit   (sdo),
        .last_fall (last_fall),
        .cfg_we    (cfg_we),
        .cfg_new   (cfg_new)
    );

    assign por_done = (por_cnt == PW'(POR_TICKS - 1));

    always_comb begin
        phase_nxt = phase;
        go_conv   = 1'b0;
        unique case (phase)
            PH_POR:  go_conv = por_done;
            PH_CONV: if (tmr_done) phase_nxt = PH_WAIT;
            PH_WAIT: if (!cs_s) phase_nxt = PH_XFER;
            PH_XFER: go_conv = last_fall || cs_rise;
            default: phase_nxt = PH_POR;
        endcase
        if (go_conv) phase_nxt = PH_CONV;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_POR;
            por_cnt <= '0;
            cfg     <= '0;
            ref_off <= 1'b0;
        end else begin
            phase <= phase_nxt;
            if (phase == PH_POR) por_cnt <= por_cnt + 1'b1;
            if (cfg_we) cfg <= cfg_new;
            if (load)
                ref_off <= cfg.deep_sleep;
            else if (phase == PH_WAIT && !cs_s)
                ref_off <= 1'b0;
        end
    end

    assign sdo_oe  = ~cs_s;
    assign adc_pwr = (phase == PH_CONV);
    assign ref_pwr = ~ref_off;
endmodule

// File: rtl/adc_cycle_ctrl_chk.sv
module adc_cycle_ctrl_chk #(
    parameter int SLOW_TICKS = 400,
    parameter int FAST_TICKS = 100
) (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sdo_oe,
    input logic adc_pwr,
    input logic ref_pwr
);
    logic [1:0] age;
    int         hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            age    <= '0;
            hi_cnt <= 0;
        end else begin
            if (age != 2'd3) age <= age + 1'b1;
            hi_cnt <= adc_pwr ? hi_cnt + 1 : 0;
        end
    end

    assert_oe_follows_cs_R8: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (sdo_oe == !$past(cs_n, 2)));

    assert_conv_length_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_pwr) |-> (hi_cnt == SLOW_TICKS || hi_cnt == FAST_TICKS));

    assert_ref_on_in_conv_R9: assert property (@(posedge clk) disable iff (rst)
        adc_pwr |-> ref_pwr);

    assert_ref_drop_at_end_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(ref_pwr) |-> $fell(adc_pwr));

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!adc_pwr && ref_pwr));
endmodule

bind adc_cycle_ctrl adc_cycle_ctrl_chk #(
    .SLOW_TICKS (SLOW_TICKS),
    .FAST_TICKS (FAST_TICKS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .sdo_oe  (sdo_oe),
    .adc_pwr (adc_pwr),
    .ref_pwr (ref_pwr)
);

// File: tb/adc_cycle_ctrl_bench.sv
module adc_cycle_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RES_W      = 16;
    localparam int SLOW       = 400;
    localparam int FAST       = 100;
    localparam int PORT       = 32;
    localparam int HALF       = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic [RES_W-1:0] result_in = 16'hA5C3;
    logic sdo, sdo_oe, adc_pwr, ref_pwr;

    int checks = 0;
    int fails  = 0;
    int run_len = 0, last_len = 0, conv_count = 0;
    logic pwr_d = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_cycle_ctrl #(
        .RES_W(RES_W), .SLOW_TICKS(SLOW), .FAST_TICKS(FAST), .POR_TICKS(PORT)
    ) u_adc_cycle_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .result_in(result_in), .sdo(sdo), .sdo_oe(sdo_oe),
        .adc_pwr(adc_pwr), .ref_pwr(ref_pwr)
    );

    // Port monitor: length of each high pulse on adc_pwr
    always @(negedge clk) begin
        if (adc_pwr) run_len <= run_len + 1;
        else begin
            if (pwr_d) begin
                last_len   <= run_len;
                conv_count <= conv_count + 1;
            end
            run_len <= 0;
        end
        pwr_d <= adc_pwr;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_conv(input int exp_len, input string req);
        int n = conv_count;
        while (conv_count == n) @(negedge clk);
        @(negedge clk);
        check(req, last_len, exp_len);
        check("R3 adc off in wait", int'(adc_pwr), 0);
    endtask

    task automatic xfer(input logic [3:0] prog, input int falls, input logic [15:0] exp);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R8 oe on", int'(sdo_oe), 1);
        check("R4 first bit D15", int'(sdo), int'(exp[15]));
        for (int i = 0; i < falls; i++) begin
            sdi = (i < 4) ? prog[3-i] : ~prog[0];
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
            repeat (HALF) @(negedge clk);
            if (i < 15) check("R4 shifted bit", int'(sdo), int'(exp[14-i]));
        end
        cs_n = 1'b1;
        sdi  = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 oe off", int'(sdo_oe), 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1 adc off in reset", int'(adc_pwr), 0);
        check("R1 ref on in reset", int'(ref_pwr), 1);
        rst = 1'b0;
        repeat (PORT / 2) @(negedge clk);
        check("R1 no conversion during por", int'(adc_pwr), 0);
        check("R8 oe off while deselected", int'(sdo_oe), 0);
        wait_conv(SLOW, "R1 first conversion slow");
    endtask

    task automatic t_plain_read;
        xfer(4'b0000, 16, 16'hA5C3);
        result_in = 16'h3C5A;
        wait_conv(SLOW, "R6 no key keeps slow; R7 full read restarts");
    endtask

    task automatic t_prog_fast;
        xfer(4'b1010, 16, 16'h3C5A);
        result_in = 16'h1234;
        wait_conv(FAST, "R5 fast rate programmed");
    endtask

    task automatic t_bad_key;
        xfer(4'b1100, 16, 16'h1234);
        result_in = 16'h0F0F;
        wait_conv(FAST, "R6 bad key leaves rate");
        check("R6 bad key leaves sleep off", int'(ref_pwr), 1);
    endtask

    task automatic t_abort;
        xfer(4'b0000, 5, 16'h0F0F);
        result_in = 16'h8001;
        wait_conv(FAST, "R7 abort starts conversion");
    endtask

    task automatic t_cs_high_ignore;
        int n = conv_count;
        for (int i = 0; i < 6; i++) begin
            sdi = 1'b1; sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
            repeat (4) @(negedge clk);
            check("R8 oe stays off", int'(sdo_oe), 0);
        end
        sdi = 1'b0;
        check("R8 no conversion from deselected sck", int'(adc_pwr), 0);
        check("R8 no conversion count change", conv_count, n);
        xfer(4'b0000, 16, 16'h8001);
        result_in = 16'h7FFE;
        wait_conv(FAST, "R8 rate unchanged by deselected sdi");
    endtask

    task automatic t_sleep;
        xfer(4'b1011, 16, 16'h7FFE);
        check("R9 ref on during conversion", int'(ref_pwr), 1);
        result_in = 16'hFFFF;
        wait_conv(FAST, "R5 fast with sleep");
        check("R9 ref off after conversion", int'(ref_pwr), 0);
        xfer(4'b1000, 16, 16'hFFFF);
        check("R9 ref back on after select", int'(ref_pwr), 1);
        result_in = 16'h0001;
        wait_conv(SLOW, "R5 slow restored");
        check("R9 sleep cleared keeps ref on", int'(ref_pwr), 1);
    endtask

    task automatic t_no_interrupt;
        xfer(4'b0000, 16, 16'h0001);
        for (int i = 0; i < 3; i++) begin
            cs_n = 1'b0; sck = 1'b1;
            repeat (8) @(negedge clk);
            sck = 1'b0; cs_n = 1'b1;
            repeat (8) @(negedge clk);
        end
        result_in = 16'h5555;
        wait_conv(SLOW, "R2 conversion not cut short");
        xfer(4'b0000, 16, 16'h5555);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_plain_read();
                t_prog_fast();
                t_bad_key();
                t_abort();
                t_cs_high_ignore();
                t_sleep();
                t_no_interrupt();
            end
            begin
                repeat (150000) @(negedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule